// File: doc/BRIEF.md
# Duration-Qualified Pattern Trigger

This block watches a small vector of sampled logic channels and decides when to raise a trigger. Each channel is either ignored or required at a given level, and the pattern holds on any sample where every required channel agrees. The block times each run of matching samples in sample-clock cycles. It can fire when a run starts or when a run ends. In its qualified mode it fires on the sample that ends a run, and only when the run's length passes a longer-than, shorter-than or window test against programmed bounds.

An event counter delays the trigger to the n-th qualifying event. In the qualified mode only the first of those n runs has to pass the duration test. The later runs only have to reach the minimum recognisable length. An optional timeout fires the trigger by itself when no event arrives. An immediate mode fires straight after arming. The trigger is a single-cycle pulse, and firing leaves the block disarmed until the next arm pulse.

Top module: `pattern_duration_trigger`

## Requirements
- R1: Channel i is compared only when `care_mask[i]`=1, and then it must equal `level_val[i]`. Channels with `care_mask[i]`=0 never affect matching.
- R2: With `mode`=1 (start), `trig` goes high in the cycle after the edge that samples the first matching sample following a non-matching one.
- R3: With `mode`=2 (end), `trig` goes high in the cycle after the edge that samples the first non-matching sample ending a run of at least MIN_DUR matching samples.
- R4: A run shorter than MIN_DUR samples is not recognised. It produces no trigger and is not counted as an event.
- R5: With `mode`=3 (qualified) and `crit`=0, a recognised run of length L fires only if L > `dur_lo`.
- R6: With `crit`=1, a run fires only if L < `dur_hi`. With `crit`=2, it fires only if `dur_lo` <= L <= `dur_hi`. With `crit`=3, no run ever fires.
- R7: The run length saturates at 2^DUR_W-1. A longer run is judged as having exactly that length.
- R8: The trigger fires on the `evt_n`-th event, with `evt_n`=0 treated as 1. In mode 3, only the first counted event must pass the duration test; later events need only be recognised runs.
- R9: With `mode`=0 (immediate), `trig` goes high in the cycle after the first edge following the arming edge.
- R10: With `auto_en`=1, if no event fires first, `trig` goes high after edge A+`timeout`+1, where A is the arming edge.
- R11: `trig` is high for one cycle only and only while armed. After it fires, the block stays disarmed and ignores events until `arm` is sampled high again. It is low after reset.
- R12: A run that ends with a failing length does not trigger. A new run starting on the very next sample is timed and judged normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp | input | N_CH | Sampled channel levels |
| care_mask | input | N_CH | 1 = channel takes part in the pattern |
| level_val | input | N_CH | Required level of each compared channel |
| mode | input | 2 | 0 immediate, 1 start, 2 end, 3 qualified |
| crit | input | 2 | 0 longer, 1 shorter, 2 window, 3 off |
| dur_lo | input | DUR_W | Lower duration bound in cycles |
| dur_hi | input | DUR_W | Upper duration bound in cycles |
| evt_n | input | EVT_W | Event number that fires (0 acts as 1) |
| auto_en | input | 1 | Enables the self-trigger timeout |
| timeout | input | TO_W | Timeout in cycles after arming |
| arm | input | 1 | Arm pulse; restarts counters |
| trig | output | 1 | Single-cycle trigger pulse |

## Verification
Runs of matching samples are driven at lengths just below, at and just above each bound, so that strict and inclusive comparisons are told apart. Runs shorter than the minimum length are placed inside event sequences, which shows that they are neither fired on nor counted. Very long runs check the saturation value against the window edges. Back-to-back runs separated by a single idle sample confirm that a failed run leaves no stale length behind. Toggling ignored channels in the middle of a run tells a masked channel apart from a compared one.

// File: rtl/pdt_pkg.sv
// Shared encodings for the duration-qualified pattern trigger.
package pdt_pkg;
    typedef enum logic [1:0] {
        TM_IMMEDIATE = 2'd0,
        TM_START     = 2'd1,
        TM_END       = 2'd2,
        TM_QUALIFIED = 2'd3
    } trig_mode_e;

    typedef enum logic [1:0] {
        DC_LONGER  = 2'd0,
        DC_SHORTER = 2'd1,
        DC_WINDOW  = 2'd2,
        DC_OFF     = 2'd3
    } dur_crit_e;
endpackage

// File: rtl/pdt_match.sv
// Per-channel pattern compare. Assumes samples are already synchronous to clk.
// A channel with care=0 always agrees; the pattern holds when all agree.
module pdt_match #(
    parameter int N_CH = 4
) (
    input  logic [N_CH-1:0] smp_i,
    input  logic [N_CH-1:0] care_i,
    input  logic [N_CH-1:0] level_i,
    output logic            match_o
);
    logic [N_CH-1:0] agree;

    genvar gi;
    generate
        for (gi = 0; gi < N_CH; gi++) begin : g_chan
            // one channel agrees if ignored or at its required level
            assign agree[gi] = !care_i[gi] || (smp_i[gi] == level_i[gi]);
        end
    endgenerate

    // all channels must agree
    assign match_o = &agree;
endmodule

// File: rtl/pdt_duration.sv
// Run-length timer. Tracks whether the previous sample matched, and counts
// matching samples in a saturating counter that restarts at 1 on entry.
// On the exit sample, len_o holds the length of the run just ended.
module pdt_duration #(
    parameter int DUR_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             match_i,
    output logic             entry_o,
    output logic             exit_o,
    output logic [DUR_W-1:0] len_o
);
    localparam logic [DUR_W-1:0] LEN_MAX = {DUR_W{1'b1}};

    logic             in_pat_q;
    logic [DUR_W-1:0] dur_q;

    // edge detection against the previous sample
    assign entry_o = match_i && !in_pat_q;
    assign exit_o  = !match_i && in_pat_q;
    assign len_o   = dur_q;

    // run-length counter with saturation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_pat_q <= 1'b0;
            dur_q    <= '0;
        end else begin
            in_pat_q <= match_i;
            if (entry_o) begin
                dur_q <= {{(DUR_W-1){1'b0}}, 1'b1};
            end else if (match_i) begin
                if (dur_q != LEN_MAX) dur_q <= dur_q + 1'b1;
            end else begin
                dur_q <= '0;
            end
        end
    end

    // a run in progress always has a nonzero length
    assert_len_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_pat_q |-> (dur_q != '0));

    // a saturated length holds while the run continues
    assert_len_saturates_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_pat_q && match_i && dur_q == LEN_MAX) |=> (dur_q == LEN_MAX));
endmodule

// File: rtl/pdt_qualifier.sv
// Judges a finished run length. recog_o: long enough to be seen at all.
// qual_o: recognised and passing the selected duration criterion.
module pdt_qualifier
    import pdt_pkg::*;
#(
    parameter int DUR_W   = 6,
    parameter int MIN_DUR = 2
) (
    input  logic [DUR_W-1:0] len_i,
    input  dur_crit_e        crit_i,
    input  logic [DUR_W-1:0] lo_i,
    input  logic [DUR_W-1:0] hi_i,
    output logic             recog_o,
    output logic             qual_o
);
    localparam logic [DUR_W-1:0] MIN_LEN = DUR_W'(MIN_DUR);

    logic pass;

    // criterion compare
    always_comb begin
        unique case (crit_i)
            DC_LONGER:  pass = (len_i > lo_i);
            DC_SHORTER: pass = (len_i < hi_i);
            DC_WINDOW:  pass = (len_i >= lo_i) && (len_i <= hi_i);
            default:    pass = 1'b0;
        endcase
    end

    // minimum length gate
    assign recog_o = (len_i >= MIN_LEN);
    assign qual_o  = recog_o && pass;
endmodule

// File: rtl/pdt_sequencer.sv
// Arming, event counting, timeout and trigger pulse generation.
// Assumes configuration is held stable while armed. Arm wins over firing.
module pdt_sequencer
    import pdt_pkg::*;
#(
    parameter int EVT_W = 4,
    parameter int TO_W  = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_i,
    input  trig_mode_e       mode_i,
    input  logic [EVT_W-1:0] evt_n_i,
    input  logic             auto_en_i,
    input  logic [TO_W-1:0]  timeout_i,
    input  logic             entry_i,
    input  logic             exit_recog_i,
    input  logic             exit_qual_i,
    output logic             trig_o
);
    localparam logic [TO_W-1:0] TO_MAX = {TO_W{1'b1}};

    logic             armed_q;
    logic             trig_q;
    logic [EVT_W-1:0] ev_cnt_q;
    logic [TO_W-1:0]  to_cnt_q;
    logic             evt;
    logic [EVT_W:0]   target;
    logic             evt_fire;
    logic             auto_fire;
    logic             fire;

    // event selection by mode; qualification only for the first event
    always_comb begin
        unique case (mode_i)
            TM_START:     evt = entry_i;
            TM_END:       evt = exit_recog_i;
            TM_QUALIFIED: evt = (ev_cnt_q == '0) ? exit_qual_i : exit_recog_i;
            default:      evt = 1'b0;
        endcase
    end

    // fire decision
    assign target    = (evt_n_i == '0) ? (EVT_W+1)'(1) : {1'b0, evt_n_i};
    assign evt_fire  = evt && (({1'b0, ev_cnt_q} + 1'b1) >= target);
    assign auto_fire = auto_en_i && (to_cnt_q == timeout_i);
    assign fire      = armed_q && !arm_i &&
                       ((mode_i == TM_IMMEDIATE) || evt_fire || auto_fire);
    assign trig_o    = trig_q;

    // arm state, counters and one-cycle trigger pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q  <= 1'b0;
            trig_q   <= 1'b0;
            ev_cnt_q <= '0;
            to_cnt_q <= '0;
        end else begin
            trig_q <= 1'b0;
            if (arm_i) begin
                armed_q  <= 1'b1;
                ev_cnt_q <= '0;
                to_cnt_q <= '0;
            end else if (armed_q) begin
                if (fire) begin
                    trig_q  <= 1'b1;
                    armed_q <= 1'b0;
                end else begin
                    if (evt) ev_cnt_q <= ev_cnt_q + 1'b1;
                    if (to_cnt_q != TO_MAX) to_cnt_q <= to_cnt_q + 1'b1;
                end
            end
        end
    end

    // firing leaves the block disarmed
    assert_disarm_on_fire_R11: assert property (@(posedge clk) disable iff (!rst_n)
        trig_q |-> !armed_q);

    // the trigger is a single-cycle pulse
    assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        trig_q |=> !trig_q);

    // a trigger only follows an armed cycle
    assert_fire_when_armed_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig_q) |-> $past(armed_q));

    // the event count stays below the firing number while armed
    assert_event_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> ({1'b0, ev_cnt_q} < target));

    // an expired timeout produces a trigger on the next cycle
    assert_timeout_fires_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !arm_i && auto_en_i && to_cnt_q == timeout_i) |=> trig_q);
endmodule

// File: rtl/pattern_duration_trigger.sv
// Top of the duration-qualified pattern trigger: channel compare, run timer,
// length judge and sequencer. Inputs are assumed synchronous to clk.
module pattern_duration_trigger
    import pdt_pkg::*;
#(
    parameter int N_CH    = 4,
    parameter int DUR_W   = 6,
    parameter int EVT_W   = 4,
    parameter int TO_W    = 12,
    parameter int MIN_DUR = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_CH-1:0]  smp,
    input  logic [N_CH-1:0]  care_mask,
    input  logic [N_CH-1:0]  level_val,
    input  logic [1:0]       mode,
    input  logic [1:0]       crit,
    input  logic [DUR_W-1:0] dur_lo,
    input  logic [DUR_W-1:0] dur_hi,
    input  logic [EVT_W-1:0] evt_n,
    input  logic             auto_en,
    input  logic [TO_W-1:0]  timeout,
    input  logic             arm,
    output logic             trig
);
    logic             match;
    logic             entry;
    logic             exit_pulse;
    logic [DUR_W-1:0] run_len;
    logic             recog;
    logic             qual;

    pdt_match #(.N_CH(N_CH)) u_match (
        .smp_i   (smp),
        .care_i  (care_mask),
        .level_i (level_val),
        .match_o (match)
    );

    pdt_duration #(.DUR_W(DUR_W)) u_duration (
        .clk     (clk),
        .rst_n   (rst_n),
        .match_i (match),
        .entry_o (entry),
        .exit_o  (exit_pulse),
        .len_o   (run_len)
    );

    pdt_qualifier #(.DUR_W(DUR_W), .MIN_DUR(MIN_DUR)) u_qualifier (
        .len_i   (run_len),
        .crit_i  (dur_crit_e'(crit)),
        .lo_i    (dur_lo),
        .hi_i    (dur_hi),
        .recog_o (recog),
        .qual_o  (qual)
    );

    pdt_sequencer #(.EVT_W(EVT_W), .TO_W(TO_W)) u_sequencer (
        .clk          (clk),
        .rst_n        (rst_n),
        .arm_i        (arm),
        .mode_i       (trig_mode_e'(mode)),
        .evt_n_i      (evt_n),
        .auto_en_i    (auto_en),
        .timeout_i    (timeout),
        .entry_i      (entry),
        .exit_recog_i (exit_pulse && recog),
        .exit_qual_i  (exit_pulse && qual),
        .trig_o       (trig)
    );
endmodule

// File: tb/pattern_duration_trigger_tb.sv
module pattern_duration_trigger_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N_CH = 4, DUR_W = 6, EVT_W = 4, TO_W = 12, MIN_DUR = 2;
    localparam logic [3:0] PAT  = 4'b1010;
    localparam logic [3:0] IDLE = 4'b0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N_CH-1:0] smp = IDLE, care_mask = 4'b1111, level_val = PAT;
    logic [1:0] mode = 2'd0, crit = 2'd0;
    logic [DUR_W-1:0] dur_lo = '0, dur_hi = '0;
    logic [EVT_W-1:0] evt_n = 4'd1;
    logic auto_en = 1'b0;
    logic [TO_W-1:0] timeout = '0;
    logic arm = 1'b0;
    logic trig;

    int vectors = 0;
    int miscompares = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pattern_duration_trigger #(
        .N_CH(N_CH), .DUR_W(DUR_W), .EVT_W(EVT_W), .TO_W(TO_W), .MIN_DUR(MIN_DUR)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .smp(smp), .care_mask(care_mask),
        .level_val(level_val), .mode(mode), .crit(crit), .dur_lo(dur_lo),
        .dur_hi(dur_hi), .evt_n(evt_n), .auto_en(auto_en), .timeout(timeout),
        .arm(arm), .trig(trig)
    );

    task automatic chk(input logic got, input logic exp, input string tag);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s: trig=%0b expected %0b at %0t", tag, got, exp, $time);
        end
    endtask

    // present one sample; return after the edge that takes it
    task automatic apply(input logic [3:0] v);
        smp = v;
        @(negedge clk);
    endtask

    // a run of len matching samples then one idle sample
    task automatic run(input int len, input logic exp, input string tag);
        for (int i = 0; i < len; i++) begin
            apply(PAT);
            chk(trig, 1'b0, tag);
        end
        apply(IDLE);
        chk(trig, exp, tag);
    endtask

    task automatic setup(input logic [1:0] m, input logic [1:0] c,
                         input int lo, input int hi, input int n);
        mode = m; crit = c; dur_lo = DUR_W'(lo); dur_hi = DUR_W'(hi);
        evt_n = EVT_W'(n); auto_en = 1'b0;
        apply(IDLE);
        apply(IDLE);
        arm = 1'b1;
        apply(IDLE);
        arm = 1'b0;
    endtask

    task automatic t_reset;
        chk(trig, 1'b0, "R11 reset");
    endtask

    task automatic t_immediate;
        setup(2'd0, 2'd0, 0, 0, 1);
        apply(IDLE); chk(trig, 1'b1, "R9 immediate");
        apply(IDLE); chk(trig, 1'b0, "R11 one cycle");
    endtask

    task automatic t_start;
        setup(2'd1, 2'd0, 0, 0, 1);
        apply(IDLE); chk(trig, 1'b0, "R2 idle");
        apply(PAT);  chk(trig, 1'b1, "R2 entry");
        apply(PAT);  chk(trig, 1'b0, "R11 pulse");
        apply(IDLE);
        apply(PAT);  chk(trig, 1'b0, "R11 disarmed");
    endtask

    task automatic t_end;
        setup(2'd2, 2'd0, 0, 0, 1);
        run(1, 1'b0, "R4 short run");
        run(2, 1'b1, "R3 exit");
        run(3, 1'b0, "R11 disarmed");
    endtask

    task automatic t_mask;
        care_mask = 4'b0011; level_val = 4'b0010;
        setup(2'd2, 2'd0, 0, 0, 1);
        apply(4'b1110); chk(trig, 1'b0, "R1 masked");
        apply(4'b0110); chk(trig, 1'b0, "R1 masked toggle");
        apply(4'b1010); chk(trig, 1'b0, "R1 masked toggle");
        apply(4'b0001); chk(trig, 1'b1, "R1 compared bit exit");
        care_mask = 4'b1111; level_val = PAT;
    endtask

    task automatic t_criteria;
        setup(2'd3, 2'd0, 4, 0, 1);
        run(4, 1'b0, "R5 equal not longer");
        run(5, 1'b1, "R5 longer");
        setup(2'd3, 2'd1, 0, 4, 1);
        run(4, 1'b0, "R6 equal not shorter");
        run(3, 1'b1, "R12 next run judged");
        setup(2'd3, 2'd2, 3, 5, 1);
        run(2, 1'b0, "R6 below window");
        run(6, 1'b0, "R6 above window");
        run(3, 1'b1, "R6 window low edge");
        setup(2'd3, 2'd2, 3, 5, 1);
        run(5, 1'b1, "R6 window high edge");
        setup(2'd3, 2'd3, 0, 63, 1);
        run(5, 1'b0, "R6 off");
        run(10, 1'b0, "R6 off");
    endtask

    task automatic t_saturate;
        setup(2'd3, 2'd0, 62, 0, 1);
        run(100, 1'b1, "R7 saturated longer");
        setup(2'd3, 2'd2, 60, 62, 1);
        run(100, 1'b0, "R7 saturated outside window");
        run(61, 1'b1, "R7 inside window");
    endtask

    task automatic t_nth;
        setup(2'd2, 2'd0, 0, 0, 3);
        run(3, 1'b0, "R8 first");
        run(1, 1'b0, "R4 not counted");
        run(3, 1'b0, "R8 second");
        run(3, 1'b1, "R8 third fires");
        setup(2'd3, 2'd0, 5, 0, 2);
        run(3, 1'b0, "R8 unqualified first");
        run(7, 1'b0, "R8 qualified first");
        run(3, 1'b1, "R8 later needs only recognition");
        setup(2'd2, 2'd0, 0, 0, 0);
        run(2, 1'b1, "R8 zero acts as one");
    endtask

    task automatic t_auto;
        setup(2'd2, 2'd0, 0, 0, 1);
        timeout = 12'd20; auto_en = 1'b1;
        for (int i = 0; i < 20; i++) begin
            apply(IDLE); chk(trig, 1'b0, "R10 before timeout");
        end
        apply(IDLE); chk(trig, 1'b1, "R10 timeout");
        setup(2'd2, 2'd0, 0, 0, 1);
        timeout = 12'd20; auto_en = 1'b1;
        run(3, 1'b1, "R10 event first");
        setup(2'd2, 2'd0, 0, 0, 1);
        timeout = 12'd0; auto_en = 1'b1;
        apply(IDLE); chk(trig, 1'b1, "R10 zero timeout");
        auto_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_immediate();
        t_start();
        t_end();
        t_mask();
        t_criteria();
        t_saturate();
        t_nth();
        t_auto();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: run did not complete");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule